// File: doc/BRIEF.md
# Stream Framing Rule Checker

This block watches one valid/ready byte stream and checks how each packet ends. A beat counts only when it is accepted, which means valid and ready are both high. On every accepted beat the block applies three rules. A beat that does not close a packet must have every keep bit set. A beat that closes a packet may be partly filled, but its set keep bits must be one unbroken run that starts at bit 0. A closing beat must carry at least one byte. A broken rule sets a sticky flag, and the first broken rule is also recorded as a code.

The block also counts accepted beats, closed packets and valid bytes. It has no output that drives the stream and never stalls it, so it can be placed on any link that needs its end-of-packet packing watched. A synchronous clear input returns the flags, the code and the counters to zero.

Top module: `stream_frame_monitor`

## Requirements
- R1: A beat is checked and counted only in a cycle where valid_i and ready_i are both high. Any other cycle changes no output.
- R2: An accepted beat with last_i low and keep_i not all ones sets flag bit 0 (not-full). If no code is held yet, err_code_o becomes 1.
- R3: An accepted beat with last_i high and keep_i nonzero with its set bits packed from bit 0 (for example 0x01, 0x0F, 0x7F, 0xFF) raises no error.
- R4: An accepted beat with last_i high and keep_i nonzero but not packed from bit 0 (for example 0x05, 0x80) sets flag bit 1 (gap). If no code is held yet, err_code_o becomes 2.
- R5: An accepted beat with last_i high and keep_i all zeros sets flag bit 2 (empty-last). If no code is held yet, err_code_o becomes 3.
- R6: Once set, a flag stays set until clear_i. err_o is high whenever any flag is set.
- R7: err_code_o keeps the code of the first violation after reset or clear. Later violations set their own flags but leave the code unchanged.
- R8: beat_cnt_o rises by one on each accepted beat. pkt_cnt_o rises by one on each accepted beat with last_i high.
- R9: byte_cnt_o rises on each accepted beat by the number of set bits in keep_i.
- R10: When clear_i is high at a clock edge, the flags, the code and all counters become zero. A beat accepted in that same cycle is discarded.
- R11: While rst_ni is low, every output is zero.
- R12: All outputs are registered. An accepted beat shows its effect right after the clock edge that accepts it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of flags, code and counters |
| valid_i | input | 1 | Stream valid, observed |
| ready_i | input | 1 | Stream ready, observed |
| last_i | input | 1 | End-of-packet marker, observed |
| keep_i | input | KEEP_W | Byte-valid mask, observed |
| err_o | output | 1 | Any sticky flag set |
| err_flags_o | output | 3 | Sticky flags: bit 0 not-full, bit 1 gap, bit 2 empty-last |
| err_code_o | output | 2 | First violation code: 0 none, 1 not-full, 2 gap, 3 empty-last |
| beat_cnt_o | output | CNT_W | Accepted beats |
| pkt_cnt_o | output | CNT_W | Accepted closing beats |
| byte_cnt_o | output | CNT_W | Sum of keep popcounts |

## Verification
Every output is a register that updates at the edge where it accepts a beat, so a fault in the rule logic or the state shows at the ports within one cycle. A wrong rule shows as a missing or extra flag after the offending beat. A lost sticky bit shows as a flag that drops before clear_i. A code that is overwritten shows as err_code_o changing on a later, different violation. A miscounted popcount or gating fault shows in byte_cnt_o or beat_cnt_o after the next beat.

// File: rtl/frame_mon_pkg.sv
`timescale 1ns/1ps
package frame_mon_pkg;
  localparam int RULE_N = 3;
  localparam int RULE_NOT_FULL = 0;
  localparam int RULE_GAP      = 1;
  localparam int RULE_EMPTY    = 2;

  typedef enum logic [1:0] {
    CODE_NONE     = 2'd0,
    CODE_NOT_FULL = 2'd1,
    CODE_GAP      = 2'd2,
    CODE_EMPTY    = 2'd3
  } err_code_e;
endpackage

// File: rtl/frame_rule_eval.sv
`timescale 1ns/1ps
module frame_rule_eval
  import frame_mon_pkg::*;
#(
  parameter int KEEP_W = 8,
  localparam int NB_W = $clog2(KEEP_W + 1)
) (
  input  logic                  beat_i,
  input  logic                  last_i,
  input  logic [KEEP_W-1:0]     keep_i,
  output logic [RULE_N-1:0]     viol_o,
  output err_code_e             code_o,
  output logic [NB_W-1:0]       nbytes_o
);
  logic full, empty, packed_lsb;
  logic [KEEP_W-1:0] keep_inc;

  assign keep_inc   = keep_i + KEEP_W'(1);
  assign full       = &keep_i;
  assign empty      = (keep_i == '0);
  // ones run from bit 0: adding one clears every set bit
  assign packed_lsb = ((keep_i & keep_inc) == '0);

  assign viol_o[RULE_NOT_FULL] = beat_i & ~last_i & ~full;
  assign viol_o[RULE_GAP]      = beat_i &  last_i & ~empty & ~packed_lsb;
  assign viol_o[RULE_EMPTY]    = beat_i &  last_i &  empty;

  always_comb begin
    if (viol_o[RULE_EMPTY])         code_o = CODE_EMPTY;
    else if (viol_o[RULE_GAP])      code_o = CODE_GAP;
    else if (viol_o[RULE_NOT_FULL]) code_o = CODE_NOT_FULL;
    else                            code_o = CODE_NONE;
  end

  always_comb begin
    nbytes_o = '0;
    for (int i = 0; i < KEEP_W; i++) nbytes_o = nbytes_o + NB_W'(keep_i[i]);
  end

  // R3
  always_comb begin
    packed_last_ok_chk: assert (!(beat_i && last_i && full) || viol_o == '0);
  end
endmodule

// File: rtl/frame_err_latch.sv
`timescale 1ns/1ps
module frame_err_latch
  import frame_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [RULE_N-1:0] viol_i,
  input  err_code_e         code_i,
  output logic [RULE_N-1:0] flags_o,
  output err_code_e         code_o
);
  logic [RULE_N-1:0] flags_q;
  err_code_e         code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      code_q  <= CODE_NONE;
    end else if (clear_i) begin
      flags_q <= '0;
      code_q  <= CODE_NONE;
    end else begin
      flags_q <= flags_q | viol_i;
      if (code_q == CODE_NONE) code_q <= code_i;
    end
  end

  assign flags_o = flags_q;
  assign code_o  = code_q;

  // R6
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R7
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && code_q != CODE_NONE) |=> $stable(code_q));
  // R2
  code_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && code_q == CODE_NONE && viol_i != '0) |=> code_q != CODE_NONE);
  // R10
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (flags_q == '0 && code_q == CODE_NONE));
endmodule

// File: rtl/frame_counters.sv
`timescale 1ns/1ps
module frame_counters #(
  parameter int CNT_W = 32,
  parameter int NB_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             beat_i,
  input  logic             last_i,
  input  logic [NB_W-1:0]  nbytes_i,
  output logic [CNT_W-1:0] beat_cnt_o,
  output logic [CNT_W-1:0] pkt_cnt_o,
  output logic [CNT_W-1:0] byte_cnt_o
);
  logic [CNT_W-1:0] beat_q, pkt_q, byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      pkt_q  <= '0;
      byte_q <= '0;
    end else if (clear_i) begin
      beat_q <= '0;
      pkt_q  <= '0;
      byte_q <= '0;
    end else if (beat_i) begin
      beat_q <= beat_q + CNT_W'(1);
      pkt_q  <= pkt_q + CNT_W'(last_i);
      byte_q <= byte_q + CNT_W'(nbytes_i);
    end
  end

  assign beat_cnt_o = beat_q;
  assign pkt_cnt_o  = pkt_q;
  assign byte_cnt_o = byte_q;

  // R1
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !beat_i) |=> ($stable(beat_q) && $stable(pkt_q) && $stable(byte_q)));
  // R8
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && beat_i) |=> beat_q == $past(beat_q) + CNT_W'(1));
  // R10
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (beat_q == '0 && pkt_q == '0 && byte_q == '0));
endmodule

// File: rtl/stream_frame_monitor.sv
`timescale 1ns/1ps
module stream_frame_monitor
  import frame_mon_pkg::*;
#(
  parameter int KEEP_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic              last_i,
  input  logic [KEEP_W-1:0] keep_i,
  output logic              err_o,
  output logic [2:0]        err_flags_o,
  output logic [1:0]        err_code_o,
  output logic [CNT_W-1:0]  beat_cnt_o,
  output logic [CNT_W-1:0]  pkt_cnt_o,
  output logic [CNT_W-1:0]  byte_cnt_o
);
  localparam int NB_W = $clog2(KEEP_W + 1);

  logic              beat;
  logic [RULE_N-1:0] viol;
  err_code_e         code_d, code_q;
  logic [NB_W-1:0]   nbytes;
  logic [RULE_N-1:0] flags;

  assign beat = valid_i & ready_i;

  frame_rule_eval #(.KEEP_W(KEEP_W)) u_eval (
    .beat_i   (beat),
    .last_i   (last_i),
    .keep_i   (keep_i),
    .viol_o   (viol),
    .code_o   (code_d),
    .nbytes_o (nbytes)
  );

  frame_err_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .viol_i  (viol),
    .code_i  (code_d),
    .flags_o (flags),
    .code_o  (code_q)
  );

  frame_counters #(.CNT_W(CNT_W), .NB_W(NB_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .beat_i     (beat),
    .last_i     (last_i),
    .nbytes_i   (nbytes),
    .beat_cnt_o (beat_cnt_o),
    .pkt_cnt_o  (pkt_cnt_o),
    .byte_cnt_o (byte_cnt_o)
  );

  assign err_flags_o = flags;
  assign err_code_o  = code_q;
  assign err_o       = |flags;

  // R6
  err_summary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(beat));
endmodule

// File: tb/stream_frame_monitor_test.sv
`timescale 1ns/1ps
module stream_frame_monitor_test;
  localparam int KEEP_W = 8;
  localparam int CNT_W  = 32;
  localparam int NV     = 18;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0, valid_i = 1'b0, ready_i = 1'b0, last_i = 1'b0;
  logic [KEEP_W-1:0] keep_i = '0;
  logic err_o;
  logic [2:0] err_flags_o;
  logic [1:0] err_code_o;
  logic [CNT_W-1:0] beat_cnt_o, pkt_cnt_o, byte_cnt_o;

  int checks = 0, failures = 0;
  logic [CNT_W-1:0] m_beats = '0, m_pkts = '0, m_bytes = '0;

  always #2ns clk_i = ~clk_i;

  stream_frame_monitor #(.KEEP_W(KEEP_W), .CNT_W(CNT_W)) uut (.*);

  // {clear, valid, ready, last, keep, exp_flags, exp_code}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,1'b0,8'hFF,3'b000,2'd0},
    {1'b0,1'b1,1'b1,1'b1,8'h0F,3'b000,2'd0},
    {1'b0,1'b1,1'b1,1'b1,8'hFF,3'b000,2'd0},
    {1'b0,1'b1,1'b0,1'b0,8'h0F,3'b000,2'd0},
    {1'b0,1'b0,1'b1,1'b1,8'h00,3'b000,2'd0},
    {1'b0,1'b1,1'b1,1'b1,8'h01,3'b000,2'd0},
    {1'b0,1'b1,1'b1,1'b1,8'h05,3'b010,2'd2},
    {1'b0,1'b1,1'b1,1'b0,8'h0F,3'b011,2'd2},
    {1'b0,1'b1,1'b1,1'b1,8'h00,3'b111,2'd2},
    {1'b1,1'b1,1'b1,1'b0,8'h00,3'b000,2'd0},
    {1'b0,1'b1,1'b1,1'b1,8'h00,3'b100,2'd3},
    {1'b0,1'b0,1'b0,1'b0,8'h00,3'b100,2'd3},
    {1'b1,1'b0,1'b0,1'b0,8'h00,3'b000,2'd0},
    {1'b0,1'b1,1'b1,1'b0,8'h7F,3'b001,2'd1},
    {1'b1,1'b0,1'b0,1'b0,8'h00,3'b000,2'd0},
    {1'b0,1'b1,1'b1,1'b1,8'h80,3'b010,2'd2},
    {1'b1,1'b0,1'b0,1'b0,8'h00,3'b000,2'd0},
    {1'b0,1'b1,1'b1,1'b1,8'h7F,3'b000,2'd0}
  };
  string TAG [NV] = '{"R3","R3","R3","R1","R1","R3","R4","R7","R5",
                      "R10","R5","R6","R10","R2","R10","R4","R10","R3"};

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic c, logic v, logic r, logic l, logic [KEEP_W-1:0] k);
    @(negedge clk_i);
    clear_i = c; valid_i = v; ready_i = r; last_i = l; keep_i = k;
    if (c) begin
      m_beats = '0; m_pkts = '0; m_bytes = '0;
    end else if (v && r) begin
      m_beats = m_beats + 1;
      m_pkts  = m_pkts + CNT_W'(l);
      m_bytes = m_bytes + CNT_W'($countones(k));
    end
    @(posedge clk_i);
    #1ns;
  endtask

  task automatic chk_cnt(string req);
    chk(req, "beats", 64'(beat_cnt_o), 64'(m_beats));
    chk(req, "pkts",  64'(pkt_cnt_o),  64'(m_pkts));
    chk(req, "bytes", 64'(byte_cnt_o), 64'(m_bytes));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #800us;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #5ns;
    // R11
    chk("R11", "flags", 64'(err_flags_o), 0);
    chk("R11", "code",  64'(err_code_o), 0);
    chk("R11", "err",   64'(err_o), 0);
    chk_cnt("R11");
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      drive(v[16], v[15], v[14], v[13], v[12:5]);
      chk(TAG[i], "flags", 64'(err_flags_o), 64'(v[4:2]));
      chk(TAG[i], "code",  64'(err_code_o),  64'(v[1:0]));
      chk("R6", "err", 64'(err_o), 64'(|v[4:2]));
      chk_cnt((m_pkts != 0) ? "R8" : "R1");
    end

    // R9: exact byte sum after a clean two-beat packet
    drive(1'b1, 1'b0, 1'b0, 1'b0, '0);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h0F);
    chk("R9", "bytes", 64'(byte_cnt_o), 12);
    chk("R8", "beats", 64'(beat_cnt_o), 2);
    chk("R8", "pkts",  64'(pkt_cnt_o), 1);

    // R12: violation not visible before the accepting edge
    @(negedge clk_i);
    clear_i = 1'b0; valid_i = 1'b1; ready_i = 1'b1; last_i = 1'b0; keep_i = 8'h03;
    #1ns;
    chk("R12", "flags before edge", 64'(err_flags_o), 0);
    @(posedge clk_i);
    #1ns;
    chk("R12", "flags after edge", 64'(err_flags_o), 1);
    chk("R12", "code after edge", 64'(err_code_o), 1);
    m_beats = m_beats + 1; m_bytes = m_bytes + 2;
    chk_cnt("R9");

    // R11: asynchronous reset mid-run
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1ns;
    chk("R11", "flags in reset", 64'(err_flags_o), 0);
    chk("R11", "beats in reset", 64'(beat_cnt_o), 0);
    chk("R11", "bytes in reset", 64'(byte_cnt_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_beats = '0; m_pkts = '0; m_bytes = '0;

    // R1: stalled bad beat held for several cycles has no effect
    for (int j = 0; j < 4; j++) drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R1", "flags", 64'(err_flags_o), 0);
    chk_cnt("R1");

    finish_run();
  end
endmodule